// File: doc/BRIEF.md
# Quarter-Wave Compressed Sine Mapper

This block turns a truncated phase word into a signed sine amplitude for a digital synthesizer. The two most significant phase bits pick the quadrant. An XOR fold mirrors the in-quadrant angle and sets the output sign, so only the first quadrant of the sine period has to be represented.

The folded 12-bit angle is split into three 4-bit fields: coarse, middle and fine. A coarse sine table is read at two addresses. One address gives the sine of the coarse angle. The other, its complement, gives the cosine from the same table, so no separate cosine table is needed. A small middle table holds the sine and cosine of the middle angle. The fine field needs no table: it adds a scaled linear term to the middle sine. The identity sin(P+Q) = sinP·cosQ + cosP·sinQ then rebuilds the amplitude with two multipliers and two adders.

The datapath is spread over three register stages. A phase accumulator drives the input, and the output feeds a converter.

Top module: `sine_quad_mapper`

## Requirements
- R1: A phase value sampled at rising edge n sets `amp_o` from edge n+2 onward (three register stages). The same phase code always yields the same amplitude, whatever phases come before or after it.
- R2: Synchronous active-low reset. Every edge with `rst_n` low clears all stages, so `amp_o` reads 0 after that edge.
- R3: For every phase code p in 0..16383, `amp_o` lies within 2 LSB of round(2047·sin(2π·p/16384)).
- R4: `amp_o` is two's complement. If phase bit 13 is 0 the output is ≥ 0. If phase bit 13 is 1 the output is ≤ 0.
- R5: Phase bit 12 mirrors the quadrant. A code with bit 12 set and bits 11:0 equal to q gives exactly the same output as the code with the same bit 13, bit 12 clear and bits 11:0 equal to the bitwise inverse of q.
- R6: Half-period antisymmetry. For any p with bit 13 clear, the output for p | 0x2000 is exactly the negation of the output for p.
- R7: The output magnitude never exceeds 2047. The code 0x800 (−2048) is never produced.
- R8: Phase 0x1000 gives exactly +2047 and phase 0x3000 gives exactly −2047. Phases 0x0000 and 0x2000 give exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_i | input | 14 | Phase word: bit 13 half-period sign, bit 12 mirror flag, bits 11:0 angle |
| amp_o | output | 12 | Registered two's-complement sine amplitude |

## Verification
The bench aims at the quadrant seams, where an off-by-one in the fold would give a visible step or a wrong value at 0x0FFF/0x1000 and at 0x2FFF/0x3000. It also aims at the crests, where accumulated rounding can carry the sum past full scale: without saturation the output would wrap to −2048 instead of +2047. The mirror and half-period pairs are compared bit for bit across the whole code space, so a wrongly inverted field or a one's-complement negation shows up at once. A random phase stream checked against the sweep results catches a pipeline whose stages are misaligned.

// File: rtl/sqm_pkg.sv
// Package: shared quadrant type and constant-time sine helpers for the mapper.
// Assumes: angles are given in half-steps of a quadrant split into 2**hs_log2 parts.
package sqm_pkg;

    // Quadrant selected by the two top phase bits.
    typedef enum logic [1:0] {
        Q_RISE   = 2'b00,
        Q_FALL   = 2'b01,
        Q_NRISE  = 2'b10,
        Q_NFALL  = 2'b11
    } quad_e;

    // pi/2 in Q30 fixed point.
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Rounded sin(pi/2 * hs / 2**hs_log2) scaled by 2**frac_w (Taylor series to x^11).
    function automatic longint sin_fixed(input longint hs, input int hs_log2, input int frac_w);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (HALF_PI_Q30 * hs) >>> hs_log2;
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return (acc + (longint'(1) <<< (29 - frac_w))) >>> (30 - frac_w);
    endfunction

    // Rounded angle of one half-step, scaled by 2**(frac_w+guard).
    function automatic longint fine_step(input int hs_log2, input int frac_w, input int guard);
        return ((HALF_PI_Q30 <<< (frac_w + guard)) + (longint'(1) <<< (29 + hs_log2)))
               >>> (30 + hs_log2);
    endfunction

endpackage

// File: rtl/sqm_fold_stage.sv
// Stage 1: folds the phase into the first quadrant using XOR and registers the
// folded angle and the output sign. Assumes PHASE_W >= 3.
module sqm_fold_stage
    import sqm_pkg::*;
#(
    parameter int PHASE_W = 14,
    localparam int ANG_W  = PHASE_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_i,
    output logic               neg_o,
    output logic [ANG_W-1:0]   ang_o
);

    quad_e            quad;
    logic             mirror;
    logic [ANG_W-1:0] folded;

    // Decode quadrant and mirror the angle in falling quadrants.
    always_comb begin
        quad   = quad_e'(phase_i[PHASE_W-1 -: 2]);
        mirror = (quad == Q_FALL) || (quad == Q_NFALL);
        folded = phase_i[ANG_W-1:0] ^ {ANG_W{mirror}};
    end

    // Register folded angle and sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_o <= 1'b0;
            ang_o <= '0;
        end else begin
            neg_o <= (quad == Q_NRISE) || (quad == Q_NFALL);
            ang_o <= folded;
        end
    end

endmodule

// File: rtl/sqm_lookup_stage.sv
// Stage 2: reads the coarse sine table twice (sine and, via complement index,
// cosine), the middle sine/cosine tables, and adds the fine linear term.
// Assumes ANG_W > 2*FIELD_W and FRAC_W <= 28. Cosine of the middle field is
// taken at the middle of its span.
module sqm_lookup_stage
    import sqm_pkg::*;
#(
    parameter int ANG_W   = 12,
    parameter int FIELD_W = 4,
    parameter int FRAC_W  = 16,
    localparam int UNIT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              neg_i,
    input  logic [ANG_W-1:0]  ang_i,
    output logic              neg_o,
    output logic [UNIT_W-1:0] sin_hi_o,
    output logic [UNIT_W-1:0] cos_hi_o,
    output logic [UNIT_W-1:0] sin_lo_o,
    output logic [UNIT_W-1:0] cos_lo_o
);

    localparam int FINE_W    = ANG_W - 2 * FIELD_W;
    localparam int HS_LOG2   = ANG_W + 1;
    localparam int N_ENT     = 1 << FIELD_W;
    localparam int COARSE_HS = 1 << (ANG_W - FIELD_W + 1);
    localparam int MID_HS    = 1 << (FINE_W + 1);
    localparam int GUARD     = 8;
    localparam logic [31:0] FINE_K = 32'(fine_step(HS_LOG2, FRAC_W, GUARD));
    localparam logic [31:0] FINE_RND = 32'(1) << (GUARD - 1);

    logic [UNIT_W-1:0] coarse_tab [N_ENT+1];
    logic [UNIT_W-1:0] mid_sin_tab [N_ENT];
    logic [UNIT_W-1:0] mid_cos_tab [N_ENT];

    // Coarse table, one extra entry holds the full-scale value for cos(0).
    for (genvar i = 0; i <= N_ENT; i++) begin : g_coarse
        localparam longint V = sin_fixed(longint'(i * COARSE_HS), HS_LOG2, FRAC_W);
        assign coarse_tab[i] = UNIT_W'(V);
    end

    // Middle tables: sine at span start, cosine at span centre.
    for (genvar j = 0; j < N_ENT; j++) begin : g_mid
        localparam longint VS = sin_fixed(longint'(j * MID_HS), HS_LOG2, FRAC_W);
        localparam longint VC = sin_fixed(longint'((1 << HS_LOG2) - (j * MID_HS + MID_HS / 2)),
                                          HS_LOG2, FRAC_W);
        assign mid_sin_tab[j] = UNIT_W'(VS);
        assign mid_cos_tab[j] = UNIT_W'(VC);
    end

    logic [FIELD_W-1:0] f_hi;
    logic [FIELD_W-1:0] f_mid;
    logic [FINE_W-1:0]  f_lo;
    logic [FIELD_W:0]   cos_idx;
    logic [UNIT_W-1:0]  fine_term;

    // Split angle, form complement index and the scaled fine term.
    always_comb begin
        f_hi      = ang_i[ANG_W-1 -: FIELD_W];
        f_mid     = ang_i[FINE_W +: FIELD_W];
        f_lo      = ang_i[FINE_W-1:0];
        cos_idx   = (FIELD_W+1)'(N_ENT) - (FIELD_W+1)'(f_hi);
        fine_term = UNIT_W'((32'({f_lo, 1'b1}) * FINE_K + FINE_RND) >> GUARD);
    end

    // Register table outputs and the first adder result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_o    <= 1'b0;
            sin_hi_o <= '0;
            cos_hi_o <= '0;
            sin_lo_o <= '0;
            cos_lo_o <= '0;
        end else begin
            neg_o    <= neg_i;
            sin_hi_o <= coarse_tab[{1'b0, f_hi}];
            cos_hi_o <= coarse_tab[cos_idx];
            sin_lo_o <= mid_sin_tab[f_mid] + fine_term;
            cos_lo_o <= mid_cos_tab[f_mid];
        end
    end

endmodule

// File: rtl/sqm_combine_stage.sv
// Stage 3: two products and one sum rebuild the sine, which is scaled to the
// output range, rounded, saturated and signed. Assumes unsigned Q(FRAC_W) inputs.
module sqm_combine_stage #(
    parameter int FRAC_W  = 16,
    parameter int AMP_W   = 12,
    localparam int UNIT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              neg_i,
    input  logic [UNIT_W-1:0] sin_hi_i,
    input  logic [UNIT_W-1:0] cos_hi_i,
    input  logic [UNIT_W-1:0] sin_lo_i,
    input  logic [UNIT_W-1:0] cos_lo_i,
    output logic [AMP_W-1:0]  amp_o
);

    localparam int PROD_W = 2 * UNIT_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SCL_W  = SUM_W + AMP_W;
    localparam logic [SCL_W-1:0] AMP_MAX = SCL_W'((1 << (AMP_W - 1)) - 1);
    localparam logic [SCL_W-1:0] RND_C   = SCL_W'(1) << (2 * FRAC_W - 1);

    logic [PROD_W-1:0] prod_a;
    logic [PROD_W-1:0] prod_b;
    logic [SUM_W-1:0]  sum_ab;
    logic [SCL_W-1:0]  scaled;
    logic [SCL_W-1:0]  mag_full;
    logic [AMP_W-1:0]  mag;

    // Angle-sum identity, scaling and saturation.
    always_comb begin
        prod_a   = PROD_W'(sin_hi_i) * PROD_W'(cos_lo_i);
        prod_b   = PROD_W'(cos_hi_i) * PROD_W'(sin_lo_i);
        sum_ab   = SUM_W'(prod_a) + SUM_W'(prod_b);
        scaled   = SCL_W'(sum_ab) * AMP_MAX + RND_C;
        mag_full = scaled >> (2 * FRAC_W);
        mag      = (mag_full > AMP_MAX) ? AMP_W'(AMP_MAX) : AMP_W'(mag_full);
    end

    // Apply sign by XOR and increment, then register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_o <= '0;
        end else begin
            amp_o <= (mag ^ {AMP_W{neg_i}}) + AMP_W'(neg_i);
        end
    end

endmodule

// File: rtl/sine_quad_mapper.sv
// Top: phase word to signed sine amplitude through fold, lookup and combine
// stages (three register stages). Assumes PHASE_W-2 > 2*FIELD_W.
module sine_quad_mapper #(
    parameter int PHASE_W = 14,
    parameter int AMP_W   = 12,
    parameter int FIELD_W = 4,
    parameter int FRAC_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [AMP_W-1:0]   amp_o
);

    localparam int ANG_W  = PHASE_W - 2;
    localparam int UNIT_W = FRAC_W + 1;

    logic              s1_neg;
    logic [ANG_W-1:0]  s1_ang;
    logic              s2_neg;
    logic [UNIT_W-1:0] s2_sin_hi;
    logic [UNIT_W-1:0] s2_cos_hi;
    logic [UNIT_W-1:0] s2_sin_lo;
    logic [UNIT_W-1:0] s2_cos_lo;

    sqm_fold_stage #(.PHASE_W(PHASE_W)) fold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_i),
        .neg_o   (s1_neg),
        .ang_o   (s1_ang)
    );

    sqm_lookup_stage #(.ANG_W(ANG_W), .FIELD_W(FIELD_W), .FRAC_W(FRAC_W)) lookup_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .neg_i    (s1_neg),
        .ang_i    (s1_ang),
        .neg_o    (s2_neg),
        .sin_hi_o (s2_sin_hi),
        .cos_hi_o (s2_cos_hi),
        .sin_lo_o (s2_sin_lo),
        .cos_lo_o (s2_cos_lo)
    );

    sqm_combine_stage #(.FRAC_W(FRAC_W), .AMP_W(AMP_W)) combine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .neg_i    (s2_neg),
        .sin_hi_i (s2_sin_hi),
        .cos_hi_i (s2_cos_hi),
        .sin_lo_i (s2_sin_lo),
        .cos_lo_i (s2_cos_lo),
        .amp_o    (amp_o)
    );

endmodule

// File: rtl/sqm_checker.sv
// Checker: port-level properties of the mapper, bound to every instance.
// Assumes the three-stage latency of the top module.
module sqm_checker #(
    parameter int PHASE_W = 14,
    parameter int AMP_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] phase_i,
    input logic [AMP_W-1:0]   amp_o
);

    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam logic [PHASE_W-1:0] PEAK_POS = PHASE_W'(1) << (PHASE_W - 2);
    localparam logic [PHASE_W-1:0] PEAK_NEG = PHASE_W'(3) << (PHASE_W - 2);

    logic [1:0] fill;
    logic       rst_seen = 1'b0;

    // Count edges since reset until the pipeline carries real data.
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= 2'd0;
        else if (fill != 2'd3) fill <= fill + 2'd1;
    end

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R2: output cleared after a reset edge.
    always @(posedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r2: assert (amp_o == '0);
        end
    end

    p_sign_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3 && !$past(phase_i[PHASE_W-1], 3)) |-> !amp_o[AMP_W-1]);

    p_sign_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3 && $past(phase_i[PHASE_W-1], 3)) |-> (amp_o[AMP_W-1] || amp_o == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        amp_o != {1'b1, {(AMP_W-1){1'b0}}});

    // R8 with R1 latency: crest values three edges after the phase.
    p_peak_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3 && $past(phase_i, 3) == PEAK_POS) |-> ($signed(amp_o) == AMP_MAX));

    p_peak_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3 && $past(phase_i, 3) == PEAK_NEG) |-> ($signed(amp_o) == -AMP_MAX));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd3 && $past(phase_i, 3) == '0) |-> (amp_o == '0));

endmodule

bind sine_quad_mapper sqm_checker #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_i),
    .amp_o   (amp_o)
);

// File: tb/sine_quad_mapper_tb_top.sv
module sine_quad_mapper_tb_top;

    localparam int PW    = 14;
    localparam int AW    = 12;
    localparam int NCODE = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] phase = '0;
    logic [AW-1:0] amp;

    always #4 clk = ~clk;

    sine_quad_mapper dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .amp_o   (amp)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int n_fill = 0;
    logic [PW-1:0] h0 = '0;
    logic [PW-1:0] h1 = '0;
    logic [PW-1:0] h2 = '0;
    int res [NCODE];
    bit seen [NCODE];

    function automatic int ref_amp(input int p);
        real a;
        a = 2.0 * 3.14159265358979 * real'(p) / real'(NCODE);
        return int'($floor(2047.0 * $sin(a) + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic observe(input int p, input int a);
        int r;
        r = ref_amp(p);
        check((a - r <= 2) && (r - a <= 2), "R3 accuracy", a, r);
        if (p >= NCODE / 2) check(a <= 0, "R4 sign negative half", a, 0);
        else                check(a >= 0, "R4 sign positive half", a, 0);
        check(a != -2048, "R7 range", a, -2047);
        if (seen[p]) check(a == res[p], "R1 latency alignment", a, res[p]);
        else begin
            seen[p] = 1'b1;
            res[p]  = a;
        end
    endtask

    task automatic cycle(input logic [PW-1:0] p);
        @(negedge clk);
        if (n_fill >= 3) observe(int'(h2), int'($signed(amp)));
        h2 = h1;
        h1 = h0;
        h0 = p;
        phase = p;
        n_fill++;
    endtask

    task automatic flush();
        repeat (3) cycle('0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase = PW'($urandom);
        @(negedge clk);
        check(amp == '0, "R2 reset clear", int'($signed(amp)), 0);
        @(negedge clk);
        check(amp == '0, "R2 reset hold", int'($signed(amp)), 0);
        rst_n = 1'b1;
        n_fill = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        void'($urandom(32'd7311));
        apply_reset();
        // Directed seams and crests (R8).
        cycle(14'h0000); cycle(14'h1000); cycle(14'h2000); cycle(14'h3000);
        cycle(14'h0FFF); cycle(14'h1FFF); cycle(14'h2FFF); cycle(14'h3FFF);
        cycle(14'h0800); cycle(14'h1800); cycle(14'h0001); cycle(14'h2001);
        flush();
        // Full sweep (R3, R4).
        for (int p = 0; p < NCODE; p++) cycle(PW'(p));
        flush();
        // R8 exact crest and zero values.
        check(res[14'h1000] == 2047,  "R8 positive crest", res[14'h1000], 2047);
        check(res[14'h3000] == -2047, "R8 negative crest", res[14'h3000], -2047);
        check(res[14'h0000] == 0,     "R8 zero at 0x0000", res[14'h0000], 0);
        check(res[14'h2000] == 0,     "R8 zero at 0x2000", res[14'h2000], 0);
        // R5 mirror pairs.
        for (int s = 0; s < 2; s++) begin
            for (int q = 0; q < 4096; q++) begin
                int pa;
                int pb;
                pa = (s << 13) | q;
                pb = (s << 13) | (1 << 12) | (~q & 12'hFFF);
                check(res[pb] == res[pa], "R5 mirror", res[pb], res[pa]);
            end
        end
        // R6 half-period antisymmetry.
        for (int p = 0; p < NCODE / 2; p++) begin
            check(res[p | 14'h2000] == -res[p], "R6 antisymmetry", res[p | 14'h2000], -res[p]);
        end
        // Random stream against sweep results (R1).
        for (int i = 0; i < 3000; i++) cycle(PW'($urandom));
        flush();
        // Mid-run reset, then more random traffic (R2, R1).
        apply_reset();
        for (int i = 0; i < 500; i++) cycle(PW'($urandom));
        flush();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule